// File: doc/BRIEF.md
# Compare-Triggered Timing Pulse Generator

This block turns a one-cycle compare strobe from a time counter into a timed output pulse. The strobe comes from a comparator outside the block. When the strobe is accepted, the block waits a programmed number of reference clock cycles and then drives the output high for a programmed number of cycles. Both counts are in reference clock cycles. As one example, a width equal to one tenth of the clock frequency gives a pulse of 100 ms.

A repeat interval of zero gives one pulse per accepted strobe. A non-zero interval makes the block launch a new pulse at that interval, counted from each rising edge, until it is disabled. This is how pulse-per-second and other periodic outputs are kept aligned to the time base.

A two-bit control word gates the whole block. Bit 0 is the global enable and bit 1 is the output enable. Clearing either bit stops the output at once. A sticky status bit records that a pulse was launched, and software clears it by writing 1.

Top module: `sync_pulse_gen`

## Requirements
- R1: During reset and right after it, `sync_out` is low and `stat_sticky` is 0.
- R2: A strobe is acted on only while `sync_ctrl` bit 0 (global enable) and bit 1 (output enable) are both 1. With either bit 0, a strobe produces no pulse and does not set the status.
- R3: When a strobe on `cmp1_evt` is accepted and `start_delay` is D, `sync_out` rises D+1 cycles after the edge that samples the strobe is presented. D = 0 therefore gives a rise on the very next cycle.
- R4: Each pulse stays high for `pulse_width` cycles. A width of 0 is treated as 1.
- R5: Clearing either enable bit forces `sync_out` low in the same cycle. It also cancels any pending delay or repetition, so enabling again produces no pulse until a new strobe arrives.
- R6: With `period` = 0, each accepted strobe gives exactly one pulse. A strobe that arrives while a delay is counting or a pulse is high is ignored.
- R7: With `period` = P > 0, a new pulse rises every P cycles after the first one until the block is disabled. Strobes that arrive while repetition is running are ignored.
- R8: `stat_sticky` goes to 1 in the cycle a pulse rises. It holds that value, even across a disable, until a cycle in which `stat_clr` is 1, after which it reads 0.
- R9: If a launch and `stat_clr` fall in the same cycle, the launch wins and `stat_sticky` reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_ctrl | input | 2 | Bit 0 global enable, bit 1 output enable |
| pulse_width | input | CW | High time in cycles (0 acts as 1) |
| period | input | CW | Repeat interval in cycles, 0 selects one-shot |
| start_delay | input | CW | Cycles from accepted strobe to rising edge |
| cmp1_evt | input | 1 | One-cycle compare-1 strobe |
| stat_clr | input | 1 | Write-1 strobe that clears the status |
| sync_out | output | 1 | Generated pulse |
| stat_sticky | output | 1 | Sticky pulse-launched flag |

## Verification
Two functions can fall in the same cycle: a pulse launch that sets the status, and a software clear that resets it. The bench provokes this by pairing a start delay of 3 with a clear strobe driven exactly three cycles after the compare strobe, starting from a status that is already 1. The outcome is judged by reading `stat_sticky` one cycle later: it must still be 1 while the pulse is high. A clear that wins would show 0. The other overlaps covered are a strobe landing inside an active delay, pulse, or repetition window, and a disable landing on a high output. Each of these is judged by counting rising edges or by the gap to the next pulse.

// File: rtl/sps_pkg.sv
// Shared definitions for the compare-triggered pulse generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sps_pkg;
    localparam int CTRL_GLOBAL_BIT = 0;
    localparam int CTRL_OUT_BIT    = 1;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_DELAY  = 2'd1,
        SEQ_REPEAT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/sps_sequencer.sv
// Decides when a pulse starts. It accepts a compare strobe only when idle
// and no pulse is high. It counts the start delay, then the repeat interval
// in periodic mode. Output launch is a combinational one-cycle strobe.
// Assumes the configuration is held stable while enabled.
module sps_sequencer
    import sps_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          cmp_evt,
    input  logic          pulse_busy,
    input  logic [CW-1:0] start_delay,
    input  logic [CW-1:0] period,
    output logic          launch
);
    localparam logic [CW-1:0] ONE = CW'(1);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // Next-state and launch decision
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        launch  = 1'b0;
        if (!run_en) begin
            state_d = SEQ_IDLE;
            cnt_d   = '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (cmp_evt && !pulse_busy) begin
                        if (start_delay == '0) begin
                            launch = 1'b1;
                            if (period != '0) begin
                                state_d = SEQ_REPEAT;
                                cnt_d   = period - ONE;
                            end
                        end else begin
                            state_d = SEQ_DELAY;
                            cnt_d   = start_delay - ONE;
                        end
                    end
                end
                SEQ_DELAY: begin
                    if (cnt_q == '0) begin
                        launch = 1'b1;
                        if (period != '0) begin
                            state_d = SEQ_REPEAT;
                            cnt_d   = period - ONE;
                        end else begin
                            state_d = SEQ_IDLE;
                        end
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                SEQ_REPEAT: begin
                    if (period == '0) begin
                        state_d = SEQ_IDLE;
                    end else if (cnt_q == '0) begin
                        launch = 1'b1;
                        cnt_d  = period - ONE;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end

    // State and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end
endmodule

// File: rtl/sps_shaper.sv
// Holds the output high for the programmed width after each launch.
// A width of 0 is treated as 1. A disable clears the pulse on the next edge.
module sps_shaper #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          launch,
    input  logic [CW-1:0] pulse_width,
    output logic          pulse_q
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] wcnt_q;
    logic [CW-1:0] width_m1;

    // Remaining high cycles after the first one
    always_comb width_m1 = (pulse_width == '0) ? '0 : pulse_width - ONE;

    // Pulse level and width counter
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            pulse_q <= 1'b0;
            wcnt_q  <= '0;
        end else if (launch) begin
            pulse_q <= 1'b1;
            wcnt_q  <= width_m1;
        end else if (pulse_q) begin
            if (wcnt_q == '0) pulse_q <= 1'b0;
            else              wcnt_q  <= wcnt_q - ONE;
        end
    end
endmodule

// File: rtl/sps_status.sv
// Sticky launch flag with write-1 clear. A launch has priority over a clear.
module sps_status (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic stat_clr,
    output logic stat_q
);
    // Set on launch, clear on strobe, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)        stat_q <= 1'b0;
        else if (launch)   stat_q <= 1'b1;
        else if (stat_clr) stat_q <= 1'b0;
    end
endmodule

// File: rtl/sync_pulse_gen.sv
// Top of the compare-triggered pulse generator. It joins the launch
// sequencer, the width shaper and the sticky status. The output is gated
// combinationally by the enables so that a disable acts in the same cycle.
module sync_pulse_gen
    import sps_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    sync_ctrl,
    input  logic [CW-1:0] pulse_width,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] start_delay,
    input  logic          cmp1_evt,
    input  logic          stat_clr,
    output logic          sync_out,
    output logic          stat_sticky
);
    logic run_en;
    logic launch;
    logic pulse_q;

    // Both enable bits are needed for any activity
    always_comb run_en = sync_ctrl[CTRL_GLOBAL_BIT] & sync_ctrl[CTRL_OUT_BIT];

    sps_sequencer #(.CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .cmp_evt    (cmp1_evt),
        .pulse_busy (pulse_q),
        .start_delay(start_delay),
        .period     (period),
        .launch     (launch)
    );

    sps_shaper #(.CW(CW)) u_shape (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .launch     (launch),
        .pulse_width(pulse_width),
        .pulse_q    (pulse_q)
    );

    sps_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .stat_clr(stat_clr),
        .stat_q  (stat_sticky)
    );

    // Immediate stop on disable
    always_comb sync_out = pulse_q & run_en;
endmodule

// File: rtl/sync_pulse_gen_chk.sv
// Temporal checks for sync_pulse_gen, attached by bind.
module sync_pulse_gen_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run_en,
    input logic          launch,
    input logic          pulse_q,
    input logic          stat_sticky,
    input logic          stat_clr,
    input logic [CW-1:0] period
);
    // R5
    off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !pulse_q);
    // R4
    rise_after_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> pulse_q);
    // R6
    oneshot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q && period == '0) |-> !launch);
    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_sticky && !stat_clr) |=> stat_sticky);
    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !launch) |=> !stat_sticky);
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> stat_sticky);
endmodule

bind sync_pulse_gen sync_pulse_gen_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .launch     (launch),
    .pulse_q    (pulse_q),
    .stat_sticky(stat_sticky),
    .stat_clr   (stat_clr),
    .period     (period)
);

// File: tb/sync_pulse_gen_bench.sv
module sync_pulse_gen_bench;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    ctrl = 2'b00;
    logic [CW-1:0] width = '0;
    logic [CW-1:0] per = '0;
    logic [CW-1:0] dly = '0;
    logic          cmp_evt = 1'b0;
    logic          stat_clr = 1'b0;
    logic          sync_out;
    logic          stat_sticky;

    int checks = 0;
    int fails = 0;

    // {delay, width, expected rise offset, expected high cycles}: R3 / R4
    localparam logic [31:0] VEC [6] = '{
        {8'd0, 8'd1, 8'd1, 8'd1},
        {8'd0, 8'd4, 8'd1, 8'd4},
        {8'd2, 8'd3, 8'd3, 8'd3},
        {8'd5, 8'd1, 8'd6, 8'd1},
        {8'd1, 8'd0, 8'd2, 8'd1},
        {8'd7, 8'd6, 8'd8, 8'd6}
    };

    always #5 clk = ~clk;

    sync_pulse_gen #(.CW(CW)) u_sync_pulse_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_ctrl  (ctrl),
        .pulse_width(width),
        .period     (per),
        .start_delay(dly),
        .cmp1_evt   (cmp_evt),
        .stat_clr   (stat_clr),
        .sync_out   (sync_out),
        .stat_sticky(stat_sticky)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fire();
        cmp_evt = 1'b1;
        @(negedge clk);
        cmp_evt = 1'b0;
    endtask

    task automatic clear_stat();
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
    endtask

    task automatic measure(input int maxc, output int rise, output int hi);
        rise = -1;
        hi = 0;
        for (int i = 1; i <= maxc; i++) begin
            if (sync_out) begin
                rise = i;
                break;
            end
            @(negedge clk);
        end
        if (rise > 0) begin
            while (sync_out && hi < 1000) begin
                hi++;
                @(negedge clk);
            end
        end
    endtask

    task automatic count_rises(input int n, output int c);
        logic prev;
        c = 0;
        prev = sync_out;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sync_out && !prev) c++;
            prev = sync_out;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int r, h, c, k;
        ctrl = 2'b11;
        repeat (3) @(negedge clk);
        chk("R1 sync_out in reset", int'(sync_out), 0);
        chk("R1 status in reset", int'(stat_sticky), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sync_out after reset", int'(sync_out), 0);
        chk("R1 status after reset", int'(stat_sticky), 0);

        // Vector table: one-shot delay and width
        for (int v = 0; v < 6; v++) begin
            dly = CW'(VEC[v][31:24]);
            width = CW'(VEC[v][23:16]);
            per = '0;
            fire();
            measure(40, r, h);
            chk($sformatf("R3 rise offset vec%0d", v), r, int'(VEC[v][15:8]));
            chk($sformatf("R4 high cycles vec%0d", v), h, int'(VEC[v][7:0]));
            chk($sformatf("R8 status set vec%0d", v), int'(stat_sticky), 1);
            clear_stat();
            chk($sformatf("R8 status cleared vec%0d", v), int'(stat_sticky), 0);
        end

        // R2: enable gating
        dly = '0; width = CW'(3); per = '0;
        ctrl = 2'b01;
        fire();
        count_rises(10, c);
        chk("R2 global only no pulse", c, 0);
        ctrl = 2'b10;
        fire();
        count_rises(10, c);
        chk("R2 output only no pulse", c, 0);
        chk("R2 status untouched", int'(stat_sticky), 0);

        // R6: strobe during active pulse ignored
        ctrl = 2'b11; dly = '0; width = CW'(5);
        fire();
        chk("R6 first pulse high", int'(sync_out), 1);
        @(negedge clk); @(negedge clk);
        fire();
        count_rises(20, c);
        chk("R6 strobe during pulse ignored", c, 0);

        // R6: strobe during delay ignored
        dly = CW'(4); width = CW'(1);
        fire();
        @(negedge clk);
        fire();
        count_rises(20, c);
        chk("R6 strobe during delay ignored", c, 1);

        // R7: periodic repetition
        dly = CW'(3); width = CW'(2); per = CW'(7);
        fire();
        measure(20, r, h);
        chk("R7 first rise", r, 4);
        chk("R7 first width", h, 2);
        k = 0;
        while (!sync_out && k < 50) begin @(negedge clk); k++; end
        chk("R7 gap to second pulse", k, 5);
        measure(5, r, h);
        chk("R7 second width", h, 2);
        fire();
        k = 0;
        while (!sync_out && k < 50) begin @(negedge clk); k++; end
        chk("R7 strobe while repeating ignored", k, 4);

        // R5: disable drops output at once and cancels repetition
        ctrl = 2'b00;
        #1;
        chk("R5 immediate stop", int'(sync_out), 0);
        @(negedge clk);
        ctrl = 2'b11;
        count_rises(30, c);
        chk("R5 repetition cancelled", c, 0);

        // R8: disable keeps status
        chk("R8 status survives disable", int'(stat_sticky), 1);

        // R9: launch and clear in the same cycle, status starts at 1
        per = '0; dly = CW'(3); width = CW'(2);
        cmp_evt = 1'b1;
        @(negedge clk);
        cmp_evt = 1'b0;
        @(negedge clk);
        @(negedge clk);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
        chk("R9 set wins over clear", int'(stat_sticky), 1);
        chk("R9 pulse launched", int'(sync_out), 1);
        repeat (4) @(negedge clk);
        clear_stat();
        chk("R8 plain clear", int'(stat_sticky), 0);

        summary();
        $finish;
    end
endmodule